// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of an asynchronous parallel memory bus and decides which bus writes form a command for the flash controller behind it. The bus has an active-low chip enable, write enable and output enable, a 17-bit address and an 8-bit data path. The three strobes are brought into the system clock domain. Only a write that has completed is then fed to a sequence tracker. That tracker looks for a two-write unlock preamble and then a command byte. It reports each finished command to the array controller as a one-cycle operation pulse. The pulse carries an operation kind, an address and a data byte.

For a byte program, the block merges the new byte with the current content of the addressed cell. A program can only clear bits, so the controller receives the byte that will actually be stored. After a byte program or a chip erase, the block holds a busy flag for a fixed number of clock cycles. While that flag is set, every bus write is dropped. A sector erase is only passed on as an operation, because the erase-window timing belongs to a separate block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write counts only while chip enable and write enable are both low and output enable is high. The write is taken when the strobe ends, and a write made with output enable low has no effect.
- R2: Writing AAh to 5555h, then 55h to 2AAAh, then F0h to 5555h produces a single operation with kind 0 (reset/read).
- R3: Writing AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h makes the next write a program. That write produces an operation of kind 1 that carries its full 17-bit address.
- R4: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by 10h to 5555h, produces an operation of kind 2 (chip erase). If the 10h goes to any other address, no operation is produced.
- R5: The erase sequence ended with 30h written to any address produces an operation of kind 3 (sector erase). It carries the full written address, with the sector number in bits 16:14, and it does not set busy.
- R6: In every command-cycle address compare, address bits 16 and 15 are ignored, and only bits 14:0 must match.
- R7: The program address is the bus address at the point where the later of chip enable and write enable falls. The program data is the bus data at the point where the earlier of the two rises.
- R8: The program operation's data byte equals the written byte AND cell_q, where cell_q is the current cell content that the array presents when the program write ends.
- R9: Busy rises in the same cycle as a program or chip-erase operation pulse. It stays high for exactly PROG_CYCLES or ERASE_CYCLES clocks, respectively, and then the decoder returns to idle on its own.
- R10: A bus write made while busy is high has no effect on the sequence state and produces no operation.
- R11: A write that does not match the expected step of a sequence, including any third-cycle command byte other than F0h, A0h or 80h, returns the decoder to idle without producing an operation.
- R12: op_pulse lasts exactly one clock cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_addr | input | 17 | Bus address |
| bus_data | input | 8 | Bus write data |
| cell_q | input | 8 | Current content of the cell being programmed, from the array |
| op_pulse | output | 1 | One-cycle operation strobe |
| op_kind | output | 2 | 0 reset, 1 program, 2 chip erase, 3 sector erase |
| op_addr | output | 17 | Address of a program or sector erase |
| op_data | output | 8 | Byte to store (written byte AND cell_q) |
| busy | output | 1 | Embedded operation in progress |

## Verification
The bench builds the decoder with two synchronizer stages, PROG_CYCLES of 40 and ERASE_CYCLES of 60. These busy windows are long enough that a complete three-write sequence fits inside a single program's busy time, so the ignore-while-busy rule can be exercised directly at the ports. They are also short enough that the bench can sweep all 256 third-cycle command bytes, all 8 sectors, all four combinations of the two don't-care address bits, and a grid of cell and data patterns. Expected operation kinds, AND results and busy lengths are computed in the bench.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'd0,
      OP_PROG  = 2'd1,
      OP_CHIP  = 2'd2,
      OP_SECT  = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_KEY2,
      SQ_CMD,
      SQ_PROG,
      SQ_EKEY1,
      SQ_EKEY2,
      SQ_ECMD
   } seq_state_e;

   localparam int unsigned CMP_W = 15;
   localparam logic [CMP_W-1:0] ADR_KEY1 = 15'h5555;
   localparam logic [CMP_W-1:0] ADR_KEY2 = 15'h2AAA;

   localparam logic [7:0] DAT_KEY1  = 8'hAA;
   localparam logic [7:0] DAT_KEY2  = 8'h55;
   localparam logic [7:0] DAT_RESET = 8'hF0;
   localparam logic [7:0] DAT_PROG  = 8'hA0;
   localparam logic [7:0] DAT_ERASE = 8'h80;
   localparam logic [7:0] DAT_CHIP  = 8'h10;
   localparam logic [7:0] DAT_SECT  = 8'h30;

endpackage

// File: rtl/flash_strobe_sync.sv
module flash_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   output logic wr_start,
   output logic wr_stop
);

   if (STAGES < 2) begin : g_bad_stages
      $error("flash_strobe_sync: STAGES must be at least 2");
   end

   logic [2:0] stg [STAGES];
   logic       act;
   logic       act_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= 3'b111;
            else        stg[i] <= {ce_n, we_n, oe_n};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= 3'b111;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign act = ~stg[STAGES-1][2] & ~stg[STAGES-1][1] & stg[STAGES-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign wr_start = act & ~act_q;
   assign wr_stop  = ~act & act_q;

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int unsigned PROG_CYCLES  = 40,
   parameter int unsigned ERASE_CYCLES = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_prog,
   input  logic load_chip,
   output logic busy
);

   localparam int unsigned MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int unsigned CNT_W = $clog2(MAXC + 1);

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_len
      $error("flash_busy_timer: busy lengths must be non-zero");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load_prog)      cnt <= CNT_W'(PROG_CYCLES);
      else if (load_chip)      cnt <= CNT_W'(ERASE_CYCLES);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_stop,
   input  logic              busy,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] cell_q,
   output logic              load_prog,
   output logic              load_chip,
   output logic              op_pulse,
   output logic [1:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);

   if (ADDR_W < CMP_W + 1 || DATA_W != 8) begin : g_bad_width
      $error("flash_seq_fsm: ADDR_W must exceed 15 and DATA_W must be 8");
   end

   seq_state_e        st, st_nxt;
   logic [ADDR_W-1:0] addr_q;
   logic              take;
   logic              is_k1, is_k2;
   logic              fire;
   op_kind_e          kind_nxt;

   assign take  = wr_stop & ~busy;
   assign is_k1 = (addr_q[CMP_W-1:0] == ADR_KEY1);
   assign is_k2 = (addr_q[CMP_W-1:0] == ADR_KEY2);

   always_comb begin
      st_nxt    = st;
      fire      = 1'b0;
      kind_nxt  = OP_RESET;
      load_prog = 1'b0;
      load_chip = 1'b0;
      if (take) begin
         st_nxt = SQ_IDLE;
         unique case (st)
            SQ_IDLE:  if (is_k1 && bus_data == DAT_KEY1) st_nxt = SQ_KEY2;
            SQ_KEY2:  if (is_k2 && bus_data == DAT_KEY2) st_nxt = SQ_CMD;
            SQ_CMD: begin
               if (is_k1) begin
                  if (bus_data == DAT_RESET) begin
                     fire     = 1'b1;
                     kind_nxt = OP_RESET;
                  end else if (bus_data == DAT_PROG) begin
                     st_nxt = SQ_PROG;
                  end else if (bus_data == DAT_ERASE) begin
                     st_nxt = SQ_EKEY1;
                  end
               end
            end
            SQ_PROG: begin
               fire      = 1'b1;
               kind_nxt  = OP_PROG;
               load_prog = 1'b1;
            end
            SQ_EKEY1: if (is_k1 && bus_data == DAT_KEY1) st_nxt = SQ_EKEY2;
            SQ_EKEY2: if (is_k2 && bus_data == DAT_KEY2) st_nxt = SQ_ECMD;
            SQ_ECMD: begin
               if (is_k1 && bus_data == DAT_CHIP) begin
                  fire      = 1'b1;
                  kind_nxt  = OP_CHIP;
                  load_chip = 1'b1;
               end else if (bus_data == DAT_SECT) begin
                  fire     = 1'b1;
                  kind_nxt = OP_SECT;
               end
            end
            default: st_nxt = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         addr_q   <= '0;
         op_pulse <= 1'b0;
         op_kind  <= OP_RESET;
         op_addr  <= '0;
         op_data  <= '0;
      end else begin
         st       <= st_nxt;
         op_pulse <= fire;
         if (wr_start && !busy) addr_q <= bus_addr;
         if (fire) begin
            op_kind <= kind_nxt;
            if (kind_nxt == OP_PROG || kind_nxt == OP_SECT) op_addr <= addr_q;
            if (kind_nxt == OP_PROG) op_data <= bus_data & cell_q;
         end
      end
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int unsigned ADDR_W       = 17,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned PROG_CYCLES  = 40,
   parameter int unsigned ERASE_CYCLES = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce_n,
   input  logic              bus_we_n,
   input  logic              bus_oe_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] cell_q,
   output logic              op_pulse,
   output logic [1:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              busy
);

   logic wr_start, wr_stop;
   logic load_prog, load_chip;

   flash_strobe_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (bus_ce_n),
      .we_n     (bus_we_n),
      .oe_n     (bus_oe_n),
      .wr_start (wr_start),
      .wr_stop  (wr_stop)
   );

   flash_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_start  (wr_start),
      .wr_stop   (wr_stop),
      .busy      (busy),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .cell_q    (cell_q),
      .load_prog (load_prog),
      .load_chip (load_chip),
      .op_pulse  (op_pulse),
      .op_kind   (op_kind),
      .op_addr   (op_addr),
      .op_data   (op_data)
   );

   flash_busy_timer #(
      .PROG_CYCLES  (PROG_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_prog (load_prog),
      .load_chip (load_chip),
      .busy      (busy)
   );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PROG_CYCLES  = 40,
   parameter int unsigned ERASE_CYCLES = 60
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] cell_q,
   input logic              op_pulse,
   input logic [1:0]        op_kind,
   input logic [DATA_W-1:0] op_data,
   input logic              busy
);

   localparam int unsigned MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int unsigned RUN_W = $clog2(MAXC + 2);

   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   assert_no_op_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      op_pulse |-> !$past(busy));

   assert_prog_raises_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse && (op_kind == 2'd1 || op_kind == 2'd2)) |-> busy);

   assert_sector_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse && op_kind == 2'd3) |-> !busy);

   assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      op_pulse |=> !op_pulse);

   assert_only_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse && op_kind == 2'd1) |-> ((op_data & ~$past(cell_q)) == '0));

   assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RUN_W'(MAXC));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
   .DATA_W       (DATA_W),
   .PROG_CYCLES  (PROG_CYCLES),
   .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cell_q   (cell_q),
   .op_pulse (op_pulse),
   .op_kind  (op_kind),
   .op_data  (op_data),
   .busy     (busy)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

   localparam int PROG_N  = 40;
   localparam int ERASE_N = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
   logic [16:0] bus_addr = '0;
   logic [7:0]  bus_data = '0;
   logic [7:0]  cell_q = 8'hFF;
   logic        op_pulse;
   logic [1:0]  op_kind;
   logic [16:0] op_addr;
   logic [7:0]  op_data;
   logic        busy;

   int vectors = 0;
   int errors  = 0;
   int pulses  = 0;
   int busy_run = 0;
   int busy_len = 0;
   logic [1:0]  last_kind;
   logic [16:0] last_addr;
   logic [7:0]  last_data;
   logic        last_busy_at_pulse;

   always #2 clk = ~clk;

   flash_cmd_decoder #(
      .SYNC_STAGES  (2),
      .PROG_CYCLES  (PROG_N),
      .ERASE_CYCLES (ERASE_N)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
      .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .cell_q(cell_q), .op_pulse(op_pulse), .op_kind(op_kind),
      .op_addr(op_addr), .op_data(op_data), .busy(busy)
   );

   always @(negedge clk) begin
      if (op_pulse) begin
         pulses++;
         last_kind = op_kind;
         last_addr = op_addr;
         last_data = op_data;
         last_busy_at_pulse = busy;
      end
      if (busy) busy_run++;
      else if (busy_run != 0) begin
         busy_len = busy_run;
         busy_run = 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [16:0] a, input logic [7:0] d);
      bus_addr = a;
      bus_data = d;
      @(negedge clk);
      bus_ce_n = 1'b0;
      bus_we_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_ce_n = 1'b1;
      bus_we_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic unlock(input logic [1:0] hi);
      wr({hi, 15'h5555}, 8'hAA);
      wr({hi, 15'h2AAA}, 8'h55);
   endtask

   task automatic erase_pre();
      unlock(2'b00);
      wr(17'h05555, 8'h80);
      unlock(2'b00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R12 reset state
      check(!busy && !op_pulse && pulses == 0, "R12 reset idle", {busy, op_pulse}, 0);

      // R2 R3 R11: sweep of every third-cycle command byte
      for (int v = 0; v < 256; v++) begin
         int exp_n;
         int exp_k;
         pulses = 0;
         unlock(2'b00);
         wr(17'h05555, 8'(v));
         exp_n = 0;
         exp_k = 0;
         if (v == 8'hF0) begin exp_n = 1; exp_k = 0; end
         else if (v == 8'hA0) begin
            cell_q = 8'hFF;
            wr(17'h01234, 8'h00);
            exp_n = 1; exp_k = 1;
         end else if (v == 8'h80) begin
            wr(17'h00000, 8'h00);
         end
         settle();
         check(pulses == exp_n && (exp_n == 0 || last_kind == 2'(exp_k)),
               "R2 R3 R11 command byte sweep", pulses * 16 + int'(last_kind), exp_n * 16 + exp_k);
      end

      // R6: don't-care high address bits in all unlock/command compares
      for (int h = 0; h < 4; h++) begin
         pulses = 0;
         unlock(2'(h));
         wr({2'(3 - h), 15'h5555}, 8'hF0);
         settle();
         check(pulses == 1 && last_kind == 2'd0, "R6 high bits ignored", pulses, 1);
      end

      // R11: low address bit mismatch aborts, next clean sequence still works
      pulses = 0;
      wr(17'h05554, 8'hAA);
      wr(17'h02AAA, 8'h55);
      wr(17'h05555, 8'hF0);
      settle();
      check(pulses == 0, "R11 bad key address aborts", pulses, 0);
      pulses = 0;
      unlock(2'b00);
      wr(17'h05555, 8'hF0);
      settle();
      check(pulses == 1, "R11 recovery after abort", pulses, 1);

      // R1: output enable low makes writes ineffective
      pulses = 0;
      bus_oe_n = 1'b0;
      unlock(2'b00);
      wr(17'h05555, 8'hF0);
      bus_oe_n = 1'b1;
      settle();
      check(pulses == 0, "R1 oe low ignored", pulses, 0);

      // R3 R8 R9: program with cell/data grid, full address incl. bits 16:15
      for (int c = 0; c < 4; c++) begin
         for (int d = 0; d < 4; d++) begin
            logic [7:0]  cv;
            logic [7:0]  dv;
            logic [16:0] av;
            cv = (c == 0) ? 8'hFF : (c == 1) ? 8'h0F : (c == 2) ? 8'hA5 : 8'h00;
            dv = (d == 0) ? 8'hFF : (d == 1) ? 8'h3C : (d == 2) ? 8'h81 : 8'h00;
            av = {2'(c), 15'(d * 4097 + 3)};
            pulses = 0;
            unlock(2'(d));
            wr({2'(c), 15'h5555}, 8'hA0);
            cell_q = cv;
            wr(av, dv);
            settle();
            cell_q = 8'hFF;
            check(pulses == 1 && last_kind == 2'd1 && last_addr == av, "R3 program address",
                  int'(last_addr), int'(av));
            check(last_data == (cv & dv), "R8 program AND", last_data, cv & dv);
            check(busy_len == PROG_N && last_busy_at_pulse, "R9 program busy length", busy_len, PROG_N);
         end
      end

      // R7: address at later falling edge, data at earlier rising edge
      pulses = 0;
      unlock(2'b00);
      wr(17'h05555, 8'hA0);
      bus_addr = 17'h1F0F0;
      bus_data = 8'h11;
      @(negedge clk);
      bus_ce_n = 1'b0;
      repeat (3) @(negedge clk);
      bus_addr = 17'h0ABCD;
      @(negedge clk);
      bus_we_n = 1'b0;
      repeat (5) @(negedge clk);
      bus_addr = 17'h1FFFF;
      bus_data = 8'h5A;
      repeat (4) @(negedge clk);
      bus_we_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_data = 8'hEE;
      repeat (2) @(negedge clk);
      bus_ce_n = 1'b1;
      settle();
      check(pulses == 1 && last_addr == 17'h0ABCD, "R7 address at later fall", last_addr, 17'h0ABCD);
      check(last_data == 8'h5A, "R7 data at earlier rise", last_data, 8'h5A);

      // R10: a reset sequence during program busy is ignored
      pulses = 0;
      unlock(2'b00);
      wr(17'h05555, 8'hA0);
      wr(17'h00042, 8'h00);
      unlock(2'b00);
      wr(17'h05555, 8'hF0);
      check(busy == 1'b1, "R10 still busy during ignored writes", busy, 1);
      settle();
      check(pulses == 1 && last_kind == 2'd1, "R10 writes while busy dropped", pulses, 1);
      pulses = 0;
      wr(17'h02AAA, 8'h55);
      wr(17'h05555, 8'hF0);
      settle();
      check(pulses == 0, "R10 busy writes left no sequence state", pulses, 0);

      // R4: chip erase and busy length
      pulses = 0;
      erase_pre();
      wr(17'h05555, 8'h10);
      settle();
      check(pulses == 1 && last_kind == 2'd2, "R4 chip erase kind", last_kind, 2);
      check(busy_len == ERASE_N, "R9 erase busy length", busy_len, ERASE_N);
      pulses = 0;
      erase_pre();
      wr(17'h05556, 8'h10);
      settle();
      check(pulses == 0, "R4 chip erase wrong address", pulses, 0);

      // R5: sector erase over all sectors
      for (int s = 0; s < 8; s++) begin
         logic [16:0] sa;
         sa = {3'(s), 14'h0123};
         pulses = 0;
         busy_len = 0;
         erase_pre();
         wr(sa, 8'h30);
         settle();
         check(pulses == 1 && last_kind == 2'd3 && last_addr[16:14] == 3'(s) && last_addr == sa,
               "R5 sector erase", int'(last_addr), int'(sa));
         check(busy_len == 0 && !last_busy_at_pulse, "R5 sector erase no busy", busy_len, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule